// File: doc/BRIEF.md
# Twisted-Pair Port Link, Collision and Jabber Controller

This block sits between the receive squelch, the transmit encoder and the media-independent side of a 10 Mbps twisted-pair port. It takes a link status, a qualified receive-activity flag, a transmit-active flag and a millisecond tick. From these it derives the carrier-sense (CRS) and collision (COL) indications. It also decides whether the transmit data path may drive the wire.

The block also guards against a stuck transmitter. If transmit stays active for longer than a jabber limit, the data path is shut off and COL is held high. Carrier sense keeps reporting the receive pair. The lockout ends only after transmit has been quiet for a separate, longer unjab interval. Link test pulses stay enabled throughout. A sticky jabber-detect bit records the event until it is cleared.

Top module: `tp_port_ctrl`

## Requirements
- R1: Reset leaves the block in the link-down state, with crs, col and txGate all low. While linkPass is low, crs and col stay low whatever rxActive does. Link-down is left at the first edge with linkPass high. A low linkPass sends the block from any state back to link-down at the next edge.
- R2: In the link-up state, txGate is 1 and crs equals rxActive.
- R3: In the link-up state, col is high exactly when txActive and rxActive are both high. During such a collision crs is also high.
- R4: In link-up, a counter advances on each msTick while txActive is high, and any cycle with txActive low clears it. At the edge that carries the JAB_MS-th consecutive tick, the block enters the jabber lockout.
- R5: During the lockout, col is 1 and txGate is 0. crs equals rxActive, so with no receive activity only col is high.
- R6: linkPulseEn is 0 during reset and 1 from the first edge after reset onward, in every state including the lockout.
- R7: During the lockout, msTicks with txActive low are counted toward UNJAB_MS. Any cycle with txActive high restarts that count. At the edge carrying the UNJAB_MS-th quiet tick, the block returns to link-up.
- R8: jabberDet goes to 1 on entry to the lockout and holds until a cycle with jabClear high. A jabber entry in the same cycle as jabClear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| linkPass | input | 1 | Link status, 1 = link good |
| rxActive | input | 1 | Qualified receive activity |
| txActive | input | 1 | Transmit stream active from the encoder |
| msTick | input | 1 | One-cycle pulse per millisecond |
| jabClear | input | 1 | Clears the sticky jabber-detect bit |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision |
| txGate | output | 1 | Transmit data path enable |
| linkPulseEn | output | 1 | Link test pulse enable |
| jabberDet | output | 1 | Sticky jabber-detect status |

## Verification
On every cycle, the assertions check four things:
- A low link forces carrier and collision low one edge later.
- A timer hit sets the sticky bit, even against a clear, and a clear with no hit drops it.
- An unjab hit re-opens the transmit gate.
- The counters stay inside their limits.

The exact trip and release edges can only be shown by the bench scenarios, which use shortened limits. So can the restart of both counts when transmit toggles, and the crs and col combinations seen inside the lockout.

// File: rtl/tp_link_pkg.sv
package tp_link_pkg;

  typedef enum logic [1:0] {
    LINK_DOWN = 2'd0,
    LINK_UP   = 2'd1,
    JAB_LOCK  = 2'd2
  } portState_e;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic runJab;
    logic runQuiet;
  } timerCmd_t;

endpackage

// File: rtl/tpTickCounter.sv
module tpTickCounter #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  input  logic tick,
  output logic hit
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign hit = run && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= hit ? '0 : cnt + 1'b1;
    end
  end

  // R4 / R7: count never passes its terminal value
  a_r4_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(cnt) < LIMIT);

  // R4 / R7: dropping run clears the count
  a_r4_r7_run_clears: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> cnt == '0);

endmodule

// File: rtl/tpJabTimers.sv
module tpJabTimers
  import tp_link_pkg::*;
#(
  parameter int JAB_MS   = 100,
  parameter int UNJAB_MS = 500
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      msTick,
  input  timerCmd_t cmd,
  output logic      jabHit,
  output logic      quietHit
);

  tpTickCounter #(.LIMIT(JAB_MS)) u_jabCnt (
    .clk  (clk),
    .rstN (rstN),
    .run  (cmd.runJab),
    .tick (msTick),
    .hit  (jabHit)
  );

  tpTickCounter #(.LIMIT(UNJAB_MS)) u_quietCnt (
    .clk  (clk),
    .rstN (rstN),
    .run  (cmd.runQuiet),
    .tick (msTick),
    .hit  (quietHit)
  );

  // the two timers are never both running
  a_r7_exclusive_run: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.runJab && cmd.runQuiet));

endmodule

// File: rtl/tpLinkCtrl.sv
module tpLinkCtrl
  import tp_link_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      linkPass,
  input  logic      rxActive,
  input  logic      txActive,
  input  logic      jabClear,
  input  logic      jabHit,
  input  logic      quietHit,
  output timerCmd_t cmd,
  output logic      crs,
  output logic      col,
  output logic      txGate,
  output logic      linkPulseEn,
  output logic      jabberDet
);

  portState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    if (!linkPass) begin
      stateD = LINK_DOWN;
    end else begin
      case (stateQ)
        LINK_DOWN: stateD = LINK_UP;
        LINK_UP:   if (jabHit) stateD = JAB_LOCK;
        JAB_LOCK:  if (quietHit) stateD = LINK_UP;
        default:   stateD = LINK_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= LINK_DOWN;
    else       stateQ <= stateD;
  end

  always_comb begin
    cmd.runJab   = linkPass && (stateQ == LINK_UP) && txActive;
    cmd.runQuiet = linkPass && (stateQ == JAB_LOCK) && !txActive;
  end

  always_comb begin
    crs    = 1'b0;
    col    = 1'b0;
    txGate = 1'b0;
    case (stateQ)
      LINK_UP: begin
        crs    = rxActive;
        col    = rxActive && txActive;
        txGate = 1'b1;
      end
      JAB_LOCK: begin
        crs    = rxActive;
        col    = 1'b1;
        txGate = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) linkPulseEn <= 1'b0;
    else       linkPulseEn <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         jabberDet <= 1'b0;
    else if (jabHit)   jabberDet <= 1'b1;
    else if (jabClear) jabberDet <= 1'b0;
  end

  a_r1_down_silent: assert property (@(posedge clk) disable iff (!rstN)
    !linkPass |=> (!crs && !col));

  a_r3_col_alone_only_locked: assert property (@(posedge clk) disable iff (!rstN)
    (col && !rxActive) |-> !txGate);

  a_r6_pulses_stay: assert property (@(posedge clk) disable iff (!rstN)
    linkPulseEn |=> linkPulseEn);

  a_r7_release_opens_gate: assert property (@(posedge clk) disable iff (!rstN)
    quietHit |=> txGate);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    jabHit |=> jabberDet);

  a_r8_clear_works: assert property (@(posedge clk) disable iff (!rstN)
    (jabClear && !jabHit) |=> !jabberDet);

endmodule

// File: rtl/tp_port_ctrl.sv
module tp_port_ctrl
  import tp_link_pkg::*;
#(
  parameter int JAB_MS   = 100,
  parameter int UNJAB_MS = 500
) (
  input  logic clk,
  input  logic rstN,
  input  logic linkPass,
  input  logic rxActive,
  input  logic txActive,
  input  logic msTick,
  input  logic jabClear,
  output logic crs,
  output logic col,
  output logic txGate,
  output logic linkPulseEn,
  output logic jabberDet
);

  timerCmd_t cmd;
  logic      jabHit;
  logic      quietHit;

  tpLinkCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .linkPass    (linkPass),
    .rxActive    (rxActive),
    .txActive    (txActive),
    .jabClear    (jabClear),
    .jabHit      (jabHit),
    .quietHit    (quietHit),
    .cmd         (cmd),
    .crs         (crs),
    .col         (col),
    .txGate      (txGate),
    .linkPulseEn (linkPulseEn),
    .jabberDet   (jabberDet)
  );

  tpJabTimers #(.JAB_MS(JAB_MS), .UNJAB_MS(UNJAB_MS)) u_timers (
    .clk      (clk),
    .rstN     (rstN),
    .msTick   (msTick),
    .cmd      (cmd),
    .jabHit   (jabHit),
    .quietHit (quietHit)
  );

endmodule

// File: tb/tp_port_ctrl_bench.sv
`timescale 1ns/100ps
module tp_port_ctrl_bench;

  localparam int JAB   = 4;
  localparam int UNJAB = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic linkPass = 1'b0, rxActive = 1'b0, txActive = 1'b0, msTick = 1'b0, jabClear = 1'b0;
  logic crs, col, txGate, linkPulseEn, jabberDet;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    logic  crs, col, gate, lpe, jab;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t item;

  always #2.5 clk = ~clk;   // 200 MHz

  tp_port_ctrl #(.JAB_MS(JAB), .UNJAB_MS(UNJAB)) u_tp_port_ctrl (
    .clk(clk), .rstN(rstN), .linkPass(linkPass), .rxActive(rxActive),
    .txActive(txActive), .msTick(msTick), .jabClear(jabClear),
    .crs(crs), .col(col), .txGate(txGate), .linkPulseEn(linkPulseEn),
    .jabberDet(jabberDet)
  );

  task automatic compare(input expItem_t e);
    nChecks++;
    if ({crs, col, txGate, linkPulseEn, jabberDet} !== {e.crs, e.col, e.gate, e.lpe, e.jab}) begin
      nFails++;
      $display("FAIL %s: crs/col/txGate/linkPulseEn/jabberDet actual %b%b%b%b%b expected %b%b%b%b%b",
               e.req, crs, col, txGate, linkPulseEn, jabberDet,
               e.crs, e.col, e.gate, e.lpe, e.jab);
    end
  endtask

  // driver: apply one cycle of stimulus, queue what must follow the edge
  task automatic cyc(input logic lp, rx, tx, tk, clr,
                     input logic eCrs, eCol, eGate, eJab, input string req);
    expItem_t e;
    @(negedge clk);
    linkPass = lp; rxActive = rx; txActive = tx; msTick = tk; jabClear = clr;
    @(posedge clk);
    e.crs = eCrs; e.col = eCol; e.gate = eGate; e.lpe = 1'b1; e.jab = eJab; e.req = req;
    expQ.push_back(e);
  endtask

  // monitor: compare shortly after each edge
  always @(posedge clk) begin
    #1;
    while (expQ.size() > 0) begin
      item = expQ.pop_front();
      compare(item);
    end
  end

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    expItem_t r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    r.crs = 0; r.col = 0; r.gate = 0; r.lpe = 0; r.jab = 0; r.req = "R1/R6 reset";
    compare(r);
    rstN = 1'b1;

    // R1: link down ignores receive activity
    cyc(0,1,0,0,0, 0,0,0,0, "R1 down");
    cyc(0,1,1,1,0, 0,0,0,0, "R1 down R6");
    cyc(1,0,0,0,0, 0,0,1,0, "R1 link up");
    // R2 / R3
    cyc(1,1,0,0,0, 1,0,1,0, "R2 crs");
    cyc(1,0,0,1,0, 0,0,1,0, "R2 idle");
    cyc(1,1,1,0,0, 1,1,1,0, "R3 collision");
    // R4: count, then clear on tx gap
    for (int i = 0; i < JAB - 1; i++) cyc(1,0,1,1,0, 0,0,1,0, "R4 counting");
    cyc(1,0,1,0,0, 0,0,1,0, "R4 no tick");
    cyc(1,0,0,0,0, 0,0,1,0, "R4 gap");
    for (int i = 0; i < JAB - 1; i++) cyc(1,0,1,1,0, 0,0,1,0, "R4 restart");
    cyc(1,0,1,1,0, 0,1,0,1, "R4 trip");
    // R5 lockout outputs
    cyc(1,1,1,1,0, 1,1,0,1, "R5 rx active");
    cyc(1,0,1,1,0, 0,1,0,1, "R5 col only R6");
    // R7 unjab with restart
    for (int i = 0; i < UNJAB - 1; i++) cyc(1,0,0,1,0, 0,1,0,1, "R7 quiet");
    cyc(1,0,1,0,0, 0,1,0,1, "R7 restart");
    for (int i = 0; i < UNJAB - 1; i++) cyc(1,0,0,1,0, 0,1,0,1, "R7 quiet again");
    cyc(1,0,0,1,0, 0,0,1,1, "R7 release R8 sticky");
    // R8 clear, then clear colliding with a new trip
    cyc(1,0,0,0,1, 0,0,1,0, "R8 clear");
    for (int i = 0; i < JAB - 1; i++) cyc(1,0,1,1,0, 0,0,1,0, "R4 second run");
    cyc(1,0,1,1,1, 0,1,0,1, "R8 set wins");
    // R1 link drop out of lockout
    cyc(0,1,1,0,0, 0,0,0,1, "R1 drop from lock R6");
    cyc(1,1,0,0,0, 1,0,1,1, "R1 back up");
    cyc(1,0,0,0,1, 0,0,1,0, "R8 final clear");

    repeat (3) @(posedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule